// File: doc/BRIEF.md
# SPI Flash Command Engine with Shared Byte Ring

This block is a register-mapped SPI master that runs exactly one flash transaction per start command. Software stores an opcode, a packed count of bytes to send and bytes to receive, and pushes outgoing bytes through a byte-wide data port into an 8-entry ring. It then sets a self-clearing start bit. The engine pulls chip select low, shifts out the opcode, then the buffered bytes, and keeps clocking until the requested response bytes have been collected.

Transmit and receive share the same ring, and the ring has a single pointer that software can read and reset. The response seen during every byte period after the opcode is written back into the ring, so the answer to the written bytes lands in front of the answer to the read bytes. Software resets the pointer and reads forward through the data port to fetch the results. The SPI clock is derived from the block clock by a divider that is chosen by a two-bit speed field.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, every readable register returns 0, the ring holds zeros, chip select is high, and the SPI clock and data-out lines are low.
- R2: Offset 0x0 holds the opcode. The opcode reads back as written and is always the first byte shifted out, most significant bit first.
- R3: Offset 0x1 holds the receive count in bits 7:4 and the send count in bits 3:0. A field above 8 is used as 8. The register reads back exactly as written and is never changed by a transaction.
- R4: Writing 1 to bit 0 of offset 0x2 while idle starts a transaction. Bit 0 of offset 0x2 reads 1 from the cycle after the start until the transaction ends, then reads 0.
- R5: Writing 1 to bit 4 of offset 0x2 while idle sets the ring pointer to 0 in the next cycle. Bit 4 always reads 0.
- R6: While idle, each write to offset 0xC stores the byte at the pointer and each read of 0xC returns the byte at the pointer. Either access advances the pointer by one, modulo 8. Ring contents change only by these writes and by captures.
- R7: Offset 0xD shows the pointer in bits 2:0 and the writable speed code in bits 5:4. Code 1 divides the clock by 2, code 2 by 3, and codes 3 and 0 by 4. Within each bit period of D cycles, SCK is low for the first D - floor(D/2) cycles and high for the rest.
- R8: A transaction sends bytes 1..W from ring positions 0..W-1, then drives MOSI low for R more bytes. The slave's data is sampled in the last cycle of each bit period, in SPI mode 0 with the most significant bit first.
- R9: The byte received in post-opcode period k (counting from 1) is stored at ring position (k-1) mod 8. Afterwards the pointer reads (W+R) mod 8.
- R10: Chip select is low from the first opcode bit to the last bit, 8*(1+W+R)*D cycles in all. It then stays high for D cycles with busy still set, and busy clears after that gap.
- R11: While busy, writes to offsets 0x0, 0x1, 0x2, 0xC and 0xD are ignored, and reads of 0xC do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, the SPI clock reference |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register byte offset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe, which advances the pointer on offset 0xC |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, a combinational function of addr_i |
| sck_o | output | 1 | SPI clock, idle low |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data from master to slave |
| miso_i | input | 1 | SPI data from slave to master |

## Verification
A start write registered at edge E0 changes the pins in the cycle right after E0. Entry i of the expected pin sequence therefore belongs to the cycle after edge E0+i. The bench builds that whole sequence, including the chip-select gap and the busy bit, the moment E0 occurs, and compares it 2 ns after every clock edge. Register effects such as pointer moves, pointer clears and ignored writes appear one cycle after the write edge. The bench reads them back through the register port only after the write strobe has been removed. Captured bytes are checked through the data port once busy has cleared, against ring contents predicted from the slave's byte stream.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BYTE_W = 8;

  localparam logic [3:0] OFF_OPC = 4'h0;
  localparam logic [3:0] OFF_CNT = 4'h1;
  localparam logic [3:0] OFF_CTL = 4'h2;
  localparam logic [3:0] OFF_DAT = 4'hC;
  localparam logic [3:0] OFF_STS = 4'hD;

  localparam int CTL_GO_BIT  = 0;
  localparam int CTL_CLR_BIT = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } eng_state_e;

  function automatic logic [3:0] clamp_cnt(input logic [3:0] v, input int max_cnt);
    return (int'(v) > max_cnt) ? 4'(max_cnt) : v;
  endfunction
endpackage

// File: rtl/spi_cmd_clkdiv.sv
module spi_cmd_clkdiv (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       sck_en_i,
  input  logic [1:0] speed_i,
  output logic       sck_o,
  output logic       bit_end_o
);
  logic [1:0] ph_q, last_ph, lo_len;

  // divide ratio: code 1 -> 2, code 2 -> 3, codes 3/0 -> 4
  always_comb begin
    unique case (speed_i)
      2'd1:    begin last_ph = 2'd1; lo_len = 2'd1; end
      2'd2:    begin last_ph = 2'd2; lo_len = 2'd2; end
      default: begin last_ph = 2'd3; lo_len = 2'd2; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ph_q <= '0;
    else if (!run_i)             ph_q <= '0;
    else if (ph_q == last_ph)    ph_q <= '0;
    else                         ph_q <= ph_q + 2'd1;
  end

  assign bit_end_o = run_i && (ph_q == last_ph);
  assign sck_o     = sck_en_i && (ph_q >= lo_len);
endmodule

// File: rtl/spi_cmd_ring.sv
module spi_cmd_ring #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic             adv_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             cap_i,
  input  logic [DW-1:0]    cap_data_i,
  input  logic [PTR_W-1:0] peek_idx_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [DW-1:0]    rdata_o,
  output logic [DW-1:0]    peek_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] ptr_q, ptr_inc;

  assign ptr_inc = (int'(ptr_q) == DEPTH - 1) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      ptr_q <= '0;
    end else begin
      if (cap_i)     mem_q[ptr_q] <= cap_data_i;
      else if (wr_i) mem_q[ptr_q] <= wdata_i;
      if (clr_i)                      ptr_q <= '0;
      else if (cap_i || wr_i || adv_i) ptr_q <= ptr_inc;
    end
  end

  assign ptr_o   = ptr_q;
  assign rdata_o = mem_q[ptr_q];
  assign peek_o  = mem_q[peek_idx_i];
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter import spi_cmd_pkg::*; #(
  parameter int TOT_W = 5,
  parameter int PTR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [3:0]        wr_cnt_i,
  input  logic [TOT_W-1:0]  total_i,
  input  logic              bit_end_i,
  input  logic              miso_i,
  input  logic [7:0]        peek_i,
  output logic [PTR_W-1:0]  peek_idx_o,
  output logic              busy_o,
  output logic              xfer_o,
  output logic              mosi_o,
  output logic              cap_o,
  output logic [7:0]        cap_data_o
);
  eng_state_e       state_q;
  logic [7:0]       sh_q;
  logic [6:0]       rx_q;
  logic [7:0]       rx_nxt;
  logic [2:0]       bit_q;
  logic [TOT_W-1:0] byte_q;   // bytes finished before the current one
  logic             byte_done;

  assign rx_nxt    = {rx_q, miso_i};
  assign byte_done = (state_q == ST_XFER) && bit_end_i && (bit_q == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      rx_q    <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_XFER;
          sh_q    <= opcode_i;
          bit_q   <= '0;
          byte_q  <= '0;
        end
        ST_XFER: if (bit_end_i) begin
          rx_q <= rx_nxt[6:0];
          if (bit_q == 3'd7) begin
            bit_q <= '0;
            if (byte_q == total_i) begin
              state_q <= ST_GAP;
              sh_q    <= '0;
            end else begin
              byte_q <= byte_q + 1'b1;
              sh_q   <= (byte_q < TOT_W'(wr_cnt_i)) ? peek_i : '0;
            end
          end else begin
            bit_q <= bit_q + 3'd1;
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end
        ST_GAP: if (bit_end_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign peek_idx_o = byte_q[PTR_W-1:0];
  assign busy_o     = (state_q != ST_IDLE);
  assign xfer_o     = (state_q == ST_XFER);
  assign mosi_o     = xfer_o && sh_q[7];
  assign cap_o      = byte_done && (byte_q != '0);
  assign cap_data_o = rx_nxt;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine import spi_cmd_pkg::*; #(
  parameter int DEPTH   = 8,
  parameter int MAX_CNT = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] addr_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       sck_o,
  output logic       cs_no,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int TOT_W = $clog2(2 * MAX_CNT + 1);

  logic [7:0]       opc_q, cnt_q;
  logic [1:0]       speed_q;
  logic             busy, xfer, bit_end, wr_ok;
  logic             go, ptr_clr, dat_wr, dat_rd, cap;
  logic [7:0]       cap_data, ring_rdata, peek_data, sts;
  logic [PTR_W-1:0] ring_ptr, peek_idx;
  logic [3:0]       wr_cnt, rd_cnt;
  logic [TOT_W-1:0] total;

  assign wr_ok   = wr_en_i && !busy;
  assign go      = wr_ok && (addr_i == OFF_CTL) && wdata_i[CTL_GO_BIT];
  assign ptr_clr = go || (wr_ok && (addr_i == OFF_CTL) && wdata_i[CTL_CLR_BIT]);
  assign dat_wr  = wr_ok && (addr_i == OFF_DAT);
  assign dat_rd  = rd_en_i && !busy && (addr_i == OFF_DAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q   <= '0;
      cnt_q   <= '0;
      speed_q <= '0;
    end else if (wr_ok) begin
      if (addr_i == OFF_OPC) opc_q   <= wdata_i;
      if (addr_i == OFF_CNT) cnt_q   <= wdata_i;
      if (addr_i == OFF_STS) speed_q <= wdata_i[5:4];
    end
  end

  always_comb begin
    wr_cnt = clamp_cnt(cnt_q[3:0], MAX_CNT);
    rd_cnt = clamp_cnt(cnt_q[7:4], MAX_CNT);
    total  = TOT_W'(wr_cnt) + TOT_W'(rd_cnt);
  end

  always_comb begin
    sts = '0;
    sts[5:4] = speed_q;
    sts[PTR_W-1:0] = ring_ptr;
    unique case (addr_i)
      OFF_OPC: rdata_o = opc_q;
      OFF_CNT: rdata_o = cnt_q;
      OFF_CTL: rdata_o = {7'd0, busy};
      OFF_DAT: rdata_o = ring_rdata;
      OFF_STS: rdata_o = sts;
      default: rdata_o = '0;
    endcase
  end

  spi_cmd_clkdiv u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy),
    .sck_en_i  (xfer),
    .speed_i   (speed_q),
    .sck_o     (sck_o),
    .bit_end_o (bit_end)
  );

  spi_cmd_ring #(.DEPTH(DEPTH), .DW(BYTE_W)) u_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (ptr_clr),
    .wr_i       (dat_wr),
    .adv_i      (dat_rd),
    .wdata_i    (wdata_i),
    .cap_i      (cap),
    .cap_data_i (cap_data),
    .peek_idx_i (peek_idx),
    .ptr_o      (ring_ptr),
    .rdata_o    (ring_rdata),
    .peek_o     (peek_data)
  );

  spi_cmd_shifter #(.TOT_W(TOT_W), .PTR_W(PTR_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (go),
    .opcode_i   (opc_q),
    .wr_cnt_i   (wr_cnt),
    .total_i    (total),
    .bit_end_i  (bit_end),
    .miso_i     (miso_i),
    .peek_i     (peek_data),
    .peek_idx_o (peek_idx),
    .busy_o     (busy),
    .xfer_o     (xfer),
    .mosi_o     (mosi_o),
    .cap_o      (cap),
    .cap_data_o (cap_data)
  );

  assign cs_no = !xfer;
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int PTR_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       addr_i,
  input logic             wr_en_i,
  input logic [7:0]       wdata_i,
  input logic             busy_i,
  input logic             cs_no,
  input logic             sck_o,
  input logic             mosi_o,
  input logic [7:0]       opc_i,
  input logic [7:0]       cnt_i,
  input logic [PTR_W-1:0] ptr_i
);
  logic idle_ctl_wr, idle_dat_wr;
  assign idle_ctl_wr = wr_en_i && !busy_i && (addr_i == 4'h2);
  assign idle_dat_wr = wr_en_i && !busy_i && (addr_i == 4'hC);

  assert_idle_pins_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (cs_no && !sck_o && !mosi_o));

  assert_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_ctl_wr && wdata_i[0]) |=> (busy_i && !cs_no));

  assert_ptr_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_ctl_wr && wdata_i[4]) |=> (ptr_i == '0));

  assert_dat_advance_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_dat_wr |=> (ptr_i == PTR_W'($past(ptr_i) + 1'b1)));

  assert_sck_framed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !cs_no);

  assert_gap_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> busy_i);

  assert_cnt_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(cnt_i));

  assert_opc_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(opc_i));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_en_i (wr_en_i),
  .wdata_i (wdata_i),
  .busy_i  (busy),
  .cs_no   (cs_no),
  .sck_o   (sck_o),
  .mosi_o  (mosi_o),
  .opc_i   (opc_q),
  .cnt_i   (cnt_q),
  .ptr_i   (ring_ptr)
);

// File: tb/tb_spi_cmd_engine.sv
`timescale 1ns/1ps
module tb_spi_cmd_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       sck, cs_n, mosi, miso;

  always #4 clk = ~clk;

  spi_cmd_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .cs_no(cs_n), .mosi_o(mosi),
    .miso_i(miso)
  );

  int n_cmp = 0, n_bad = 0;
  logic [3:0] exp_q[$];   // {cs_n, sck, mosi, busy} per cycle
  logic [3:0] e_cur;
  bit park = 0;
  logic [7:0] mbuf [8];
  int mptr = 0;
  logic [1:0] mspeed = 0;
  logic [7:0] resp [18];
  int seed = 3;

  // mode-0 slave: next bit after each SCK fall, restarting when chip select falls
  int fall_cnt = 0, base = 0, sb;
  always @(negedge sck) fall_cnt++;
  always @(negedge cs_n) base = fall_cnt;
  always @* begin
    sb = fall_cnt - base;
    miso = (sb >= 0 && sb < 144) ? resp[sb / 8][7 - (sb % 8)] : 1'b0;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      e_cur = (exp_q.size() > 0) ? exp_q.pop_front() : 4'b1000;
      chk("R10 cs_n", 32'(cs_n), 32'(e_cur[3]));
      chk("R7 sck", 32'(sck), 32'(e_cur[2]));
      chk("R8 mosi", 32'(mosi), 32'(e_cur[1]));
      if (park) chk("R4 busy", 32'(rdata[0]), 32'(e_cur[0]));
    end
  end

  task automatic bw(logic [3:0] a, logic [7:0] d);
    @(negedge clk); park = 0; addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic br(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); park = 0; addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic push(logic [7:0] d);
    bw(4'hC, d); mbuf[mptr] = d; mptr = (mptr + 1) % 8;
  endtask

  task automatic pop_chk(string tag);
    logic [7:0] v;
    br(4'hC, v); chk(tag, 32'(v), 32'(mbuf[mptr])); mptr = (mptr + 1) % 8;
  endtask

  task automatic ptr0();
    bw(4'h2, 8'h10); mptr = 0;
  endtask

  task automatic chk_sts(string tag);
    logic [7:0] v;
    br(4'hD, v);
    chk({tag, " ptr"}, 32'(v[2:0]), 32'(mptr));
    chk({tag, " speed"}, 32'(v[5:4]), 32'(mspeed));
  endtask

  task automatic set_speed(logic [1:0] s);
    bw(4'hD, {2'b00, s, 4'h0}); mspeed = s;
  endtask

  // w, r are the effective (clamped) counts
  task automatic exec(logic [7:0] opc, int w, int r);
    int dv, lo, n;
    logic [7:0] tx;
    dv = (mspeed == 2'd1) ? 2 : (mspeed == 2'd2) ? 3 : 4;
    lo = dv - dv / 2;
    n = 1 + w + r;
    for (int k = 0; k < 18; k++) resp[k] = 8'hA5 ^ 8'(k * 29 + seed);
    seed += 11;
    @(negedge clk); park = 0; addr = 4'h2; wdata = 8'h01; wr_en = 1'b1;
    @(posedge clk);
    for (int k = 0; k < n; k++) begin
      tx = (k == 0) ? opc : (k <= w) ? mbuf[k - 1] : 8'h00;
      for (int b = 0; b < 8; b++)
        for (int p = 0; p < dv; p++)
          exp_q.push_back({1'b0, (p >= lo), tx[7 - b], 1'b1});
    end
    for (int p = 0; p < dv; p++) exp_q.push_back(4'b1001);
    for (int k = 1; k <= w + r; k++) mbuf[(k - 1) % 8] = resp[k];
    mptr = (w + r) % 8;
    @(negedge clk); wr_en = 1'b0; addr = 4'h2; park = 1;
  endtask

  task automatic wait_done();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R4 busy never cleared act=running exp=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 8; i++) mbuf[i] = 8'h00;
    for (int k = 0; k < 18; k++) resp[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    br(4'h0, v); chk("R1 opcode reset", 32'(v), 0);
    br(4'h1, v); chk("R1 count reset", 32'(v), 0);
    br(4'h2, v); chk("R1 control reset", 32'(v), 0);
    chk_sts("R1 status reset");
    pop_chk("R1 ring zero");

    // R5: pointer clear, bit reads 0
    ptr0();
    br(4'h2, v); chk("R5 clear bit reads 0", 32'(v), 0);
    chk_sts("R5 pointer cleared");

    // R2 R3 R8 R9: speed 1, three sent, two received
    set_speed(2'd1);
    bw(4'h0, 8'h9F); bw(4'h1, 8'h23);
    br(4'h0, v); chk("R2 opcode readback", 32'(v), 32'h9F);
    ptr0(); push(8'hC3); push(8'h5A); push(8'h81);
    chk_sts("R6 pointer after pushes");
    exec(8'h9F, 3, 2); wait_done();
    chk_sts("R9 pointer W+R");
    br(4'h1, v); chk("R3 count unchanged", 32'(v), 32'h23);
    ptr0(); for (int i = 0; i < 5; i++) pop_chk("R9 captured byte");

    // speed 2, receive only
    set_speed(2'd2);
    bw(4'h0, 8'h05); bw(4'h1, 8'h40); ptr0();
    exec(8'h05, 0, 4); wait_done();
    chk_sts("R9 pointer read-only");
    ptr0(); for (int i = 0; i < 4; i++) pop_chk("R9 read-only capture");

    // R3 clamp, wrap of captures past 8
    set_speed(2'd3);
    bw(4'h1, 8'hFF); bw(4'h0, 8'h0B); ptr0();
    for (int i = 0; i < 8; i++) push(8'(8'h10 + i * 7));
    exec(8'h0B, 8, 8); wait_done();
    br(4'h1, v); chk("R3 clamp readback", 32'(v), 32'hFF);
    chk_sts("R9 wrapped pointer");
    ptr0(); for (int i = 0; i < 8; i++) pop_chk("R9 wrap capture");

    // R7 reserved code divides by 4
    set_speed(2'd0);
    bw(4'h0, 8'h06); bw(4'h1, 8'h01); ptr0(); push(8'hE7);
    exec(8'h06, 1, 0); wait_done();
    chk_sts("R7 reserved speed");

    // R11: accesses while busy are ignored
    set_speed(2'd3);
    bw(4'h0, 8'h3B); bw(4'h1, 8'h22); ptr0(); push(8'h11); push(8'h22);
    exec(8'h3B, 2, 2);
    repeat (10) @(negedge clk);
    bw(4'h0, 8'h77); bw(4'h1, 8'h33); bw(4'hC, 8'h99); bw(4'hD, 8'h10);
    bw(4'h2, 8'h10); br(4'hC, v);
    park = 1; addr = 4'h2;
    wait_done();
    br(4'h0, v); chk("R11 opcode kept", 32'(v), 32'h3B);
    br(4'h1, v); chk("R11 count kept", 32'(v), 32'h22);
    chk_sts("R11 pointer and speed kept");
    ptr0(); for (int i = 0; i < 4; i++) pop_chk("R11 ring kept");

    // R6: pointer wraps modulo 8
    ptr0();
    for (int i = 0; i < 10; i++) push(8'(8'h40 + i));
    chk_sts("R6 pointer wrap");
    ptr0(); for (int i = 0; i < 8; i++) pop_chk("R6 ring contents");

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule